// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a register-programmed SPI flash master. It runs one flash command cycle at a time. Software fills a small table of eight opcodes and a 2-bit type code for each entry, and it loads two prefix opcodes, a 24-bit flash address and up to 64 data bytes. It then writes a control word that names a table entry and sets the go bit. The sequencer drives chip select low and shifts out the chosen opcode. It follows with the address bytes when the entry's type calls for them, then moves data to or from the buffer. At the end it raises a done flag.

An optional atomic mode sends one of the two prefix opcodes in a frame of its own before the main command, for example a write-enable. No other cycle can be placed between the two frames. A command is refused, and a blocked flag is raised, when the chosen table entry holds opcode 0x00 or when the data length is not one the block supports. A lockdown bit freezes the opcode table, the type word and the prefix word until reset.

The SPI pins run in mode 0. SCK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. Each SCK half-period lasts `SCK_HALF` system clocks.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset the status word reads 0x0000 and the control word reads 0x0000. spi_cs_n is high and spi_sck is low.
- R2: Register map, by word address:
  - 0x00: control word. Bits 13:8 hold the byte count minus one, bits 6:4 the table index, bit 3 the prefix select, bit 2 the atomic bit, bit 1 the data-phase enable and bit 0 the go bit. The go bit reads back as 0.
  - 0x01: status word. Bit 0 is busy, bit 1 done, bit 2 blocked and bit 3 lockdown.
  - 0x02 and 0x03: address bits 15:0 and 23:16.
  - 0x04: prefix word, with prefix 0 in bits 7:0 and prefix 1 in bits 15:8.
  - 0x05: type word, with the type of entry i in bits 2i+1:2i.
  - 0x08 to 0x0F: opcode table entries 0 to 7, in bits 7:0.
  - 0x40 to 0x7F: data buffer bytes 0 to 63.
- R3: Type code bit 1 set means three address bytes follow the opcode, sent MSB first. Bit 0 set means the data phase writes; clear means it reads. So 00 is read without address, 01 write without address, 10 read with address and 11 write with address.
- R4: In a read data phase, the byte received in position k of the data phase is stored in buffer byte k, and MOSI carries 0xFF. In a write data phase, buffer byte k is sent in position k.
- R5: With the atomic bit set, the selected prefix (prefix 1 if prefix select is 1, otherwise prefix 0) goes out alone in a first chip-select frame. The main command follows in a second frame.
- R6: With the data-phase enable clear, no data bytes are sent, whatever the byte count.
- R7: A go that selects a table entry holding 0x00 sets blocked, starts no frame and leaves done clear.
- R8: With the data phase enabled, a length of 1 to 8, 16, 24, 32, 40, 48, 56 or 64 bytes is accepted. Any other length sets blocked and starts no frame.
- R9: Done is set when a cycle ends. Writing 1 to status bit 1 clears done, and writing 1 to bit 2 clears blocked.
- R10: A control-word write while busy is ignored. The running command is unaffected and no new command starts.
- R11: Writing 1 to status bit 3 sets lockdown. After that, writes to the table, the type word and the prefix word have no effect, and lockdown stays set until reset.
- R12: spi_cs_n is high whenever the block is not busy, and spi_sck is low whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench runs the command path with all four type codes:
- A read with address shows that the three address bytes are sent MSB first and that incoming bytes land in the buffer from offset 0.
- A write without address shows that buffer bytes are sent and that no address bytes are sent.
- An opcode-only command shows that the data phase is dropped when it is disabled.
- An atomic write-with-address shows the split into two frames and which prefix was chosen.

A 16-byte read checks the first multiple-of-eight length, and a 10-byte request checks a length that is refused. A zero opcode, a go while busy and writes after lockdown are each checked at the pins and at the readback registers.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_GAP, S_CMD, S_ADR, S_DAT, S_END
    } seq_state_e;

    localparam int A_CTRL    = 0;
    localparam int A_STAT    = 1;
    localparam int A_ADRL    = 2;
    localparam int A_ADRH    = 3;
    localparam int A_PREF    = 4;
    localparam int A_TYPE    = 5;
    localparam int MENU_BASE = 8;
    localparam int BUF_BASE  = 64;
endpackage

// File: rtl/seq_sck_tick.sv
module seq_sck_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == CW'(HALF - 1));

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/seq_byte_shift.sv
module seq_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    typedef struct packed {
        logic       act;
        logic       sck;
        logic [2:0] bc;
        logic [7:0] so;
        logic [7:0] si;
        logic       done;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (start) begin
            d.act = 1'b1;
            d.sck = 1'b0;
            d.bc  = '0;
            d.so  = tx;
        end else if (q.act && tick) begin
            if (!q.sck) begin
                d.sck = 1'b1;
                d.si  = {q.si[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bc == 3'd7) begin
                    d.act  = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bc = q.bc + 3'd1;
                    d.so = {q.so[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.act;
    assign sck    = q.sck;
    assign mosi   = q.so[7];
    assign done   = q.done;
    assign rx     = q.si;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import seq_pkg::*;
#(
    parameter int MENU_N    = 8,
    parameter int BUF_BYTES = 64,
    parameter int ADDR_W    = 24,
    parameter int SCK_HALF  = 2,
    parameter int RA_W      = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [15:0]     reg_rdata,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    localparam int IDX_W  = $clog2(MENU_N);
    localparam int CNT_W  = $clog2(BUF_BYTES);
    localparam int ABYTES = ADDR_W / 8;
    localparam int TYPE_W = 2 * MENU_N;
    localparam int AHI_W  = ADDR_W - 16;

    typedef struct packed {
        seq_state_e                   st;
        logic [CNT_W-1:0]             n;
        logic                         kick;
        logic                         cs_n;
        logic                         done;
        logic                         blk;
        logic                         lock;
        logic [IDX_W-1:0]             idx;
        logic                         psel;
        logic                         atom;
        logic                         dc;
        logic [CNT_W-1:0]             len_m1;
        logic [ADDR_W-1:0]            adr;
        logic [15:0]                  pref;
        logic [TYPE_W-1:0]            otype;
        logic [MENU_N-1:0][7:0]       menu;
        logic [BUF_BYTES-1:0][7:0]    dbuf;
    } seq_t;

    seq_t d, q;

    logic       sh_active, sh_done, sh_tick;
    logic [7:0] sh_rx, tx_byte;
    logic       busy;
    logic [7:0] sel_op;
    logic [1:0] sel_type;

    seq_sck_tick #(.HALF(SCK_HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(sh_active), .tick(sh_tick)
    );

    seq_byte_shift u_shift (
        .clk(clk), .rst_n(rst_n), .start(q.kick), .tx(tx_byte),
        .tick(sh_tick), .miso(spi_miso), .active(sh_active),
        .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
    );

    assign busy     = (q.st != S_IDLE);
    assign sel_op   = q.menu[q.idx];
    assign sel_type = q.otype[2*q.idx +: 2];
    assign spi_cs_n = q.cs_n;

    // byte presented to the shifter in the current phase
    always_comb begin
        case (q.st)
            S_PRE:   tx_byte = q.psel ? q.pref[15:8] : q.pref[7:0];
            S_CMD:   tx_byte = sel_op;
            S_ADR:   tx_byte = q.adr[(ABYTES - 1 - int'(q.n)) * 8 +: 8];
            S_DAT:   tx_byte = sel_type[0] ? q.dbuf[q.n] : 8'hFF;
            default: tx_byte = 8'h00;
        endcase
    end

    logic [CNT_W-1:0] w_len_m1;
    logic [IDX_W-1:0] w_idx;
    logic [CNT_W:0]   w_len;
    logic             w_len_ok;
    logic [IDX_W-1:0] m_i;
    logic [CNT_W-1:0] b_i;
    logic             is_menu, is_buf;

    assign w_len_m1 = reg_wdata[8 +: CNT_W];
    assign w_idx    = reg_wdata[4 +: IDX_W];
    assign w_len    = {1'b0, w_len_m1} + 1'b1;
    assign w_len_ok = (w_len <= (CNT_W+1)'(8)) || (w_len[2:0] == 3'd0);
    assign m_i      = IDX_W'(reg_addr - RA_W'(MENU_BASE));
    assign b_i      = reg_addr[CNT_W-1:0];
    assign is_menu  = (reg_addr >= RA_W'(MENU_BASE)) && (reg_addr < RA_W'(MENU_BASE + MENU_N));
    assign is_buf   = (reg_addr >= RA_W'(BUF_BASE));

    always_comb begin
        d = q;
        d.kick = 1'b0;

        // command engine
        case (q.st)
            S_PRE: if (sh_done) begin
                d.st   = S_GAP;
                d.cs_n = 1'b1;
            end
            S_GAP: begin
                d.st   = S_CMD;
                d.cs_n = 1'b0;
                d.kick = 1'b1;
            end
            S_CMD: if (sh_done) begin
                d.n = '0;
                if (sel_type[1]) begin
                    d.st = S_ADR; d.kick = 1'b1;
                end else if (q.dc) begin
                    d.st = S_DAT; d.kick = 1'b1;
                end else begin
                    d.st = S_END;
                end
            end
            S_ADR: if (sh_done) begin
                if (q.n == CNT_W'(ABYTES - 1)) begin
                    d.n = '0;
                    if (q.dc) begin
                        d.st = S_DAT; d.kick = 1'b1;
                    end else begin
                        d.st = S_END;
                    end
                end else begin
                    d.n = q.n + 1'b1; d.kick = 1'b1;
                end
            end
            S_DAT: if (sh_done) begin
                if (!sel_type[0]) d.dbuf[q.n] = sh_rx;
                if (q.n == q.len_m1) begin
                    d.st = S_END;
                end else begin
                    d.n = q.n + 1'b1; d.kick = 1'b1;
                end
            end
            S_END: begin
                d.st   = S_IDLE;
                d.cs_n = 1'b1;
                d.done = 1'b1;
            end
            default: ;
        endcase

        // register writes
        if (reg_wr) begin
            if (reg_addr == RA_W'(A_CTRL)) begin
                if (!busy) begin
                    d.len_m1 = w_len_m1;
                    d.idx    = w_idx;
                    d.psel   = reg_wdata[3];
                    d.atom   = reg_wdata[2];
                    d.dc     = reg_wdata[1];
                    if (reg_wdata[0]) begin
                        if (q.menu[w_idx] == 8'h00 || (reg_wdata[1] && !w_len_ok)) begin
                            d.blk = 1'b1;
                        end else begin
                            d.st   = reg_wdata[2] ? S_PRE : S_CMD;
                            d.cs_n = 1'b0;
                            d.kick = 1'b1;
                            d.n    = '0;
                        end
                    end
                end
            end else if (reg_addr == RA_W'(A_STAT)) begin
                if (reg_wdata[1]) d.done = 1'b0;
                if (reg_wdata[2]) d.blk  = 1'b0;
                if (reg_wdata[3]) d.lock = 1'b1;
            end else if (reg_addr == RA_W'(A_ADRL)) begin
                d.adr[15:0] = reg_wdata;
            end else if (reg_addr == RA_W'(A_ADRH)) begin
                d.adr[ADDR_W-1:16] = reg_wdata[AHI_W-1:0];
            end else if (reg_addr == RA_W'(A_PREF)) begin
                if (!q.lock) d.pref = reg_wdata;
            end else if (reg_addr == RA_W'(A_TYPE)) begin
                if (!q.lock) d.otype = reg_wdata[TYPE_W-1:0];
            end else if (is_menu) begin
                if (!q.lock) d.menu[m_i] = reg_wdata[7:0];
            end else if (is_buf) begin
                d.dbuf[b_i] = reg_wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // register readback
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_W'(A_CTRL)) begin
            reg_rdata[8 +: CNT_W] = q.len_m1;
            reg_rdata[4 +: IDX_W] = q.idx;
            reg_rdata[3]          = q.psel;
            reg_rdata[2]          = q.atom;
            reg_rdata[1]          = q.dc;
        end else if (reg_addr == RA_W'(A_STAT)) begin
            reg_rdata[3:0] = {q.lock, q.blk, q.done, busy};
        end else if (reg_addr == RA_W'(A_ADRL)) begin
            reg_rdata = q.adr[15:0];
        end else if (reg_addr == RA_W'(A_ADRH)) begin
            reg_rdata[AHI_W-1:0] = q.adr[ADDR_W-1:16];
        end else if (reg_addr == RA_W'(A_PREF)) begin
            reg_rdata = q.pref;
        end else if (reg_addr == RA_W'(A_TYPE)) begin
            reg_rdata[TYPE_W-1:0] = q.otype;
        end else if (is_menu) begin
            reg_rdata[7:0] = q.menu[m_i];
        end else if (is_buf) begin
            reg_rdata[7:0] = q.dbuf[b_i];
        end
    end

    logic chk_busy, chk_done, chk_blk, chk_lock;
    assign chk_busy = busy;
    assign chk_done = q.done;
    assign chk_blk  = q.blk;
    assign chk_lock = q.lock;
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cs_n,
    input logic sck,
    input logic done,
    input logic blk,
    input logic lock
);
    assert_cs_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_sck_framed_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_block_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk) |-> (!busy && cs_n));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
endmodule

bind spi_cmd_seq seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(chk_busy), .cs_n(spi_cs_n),
    .sck(spi_sck), .done(chk_done), .blk(chk_blk), .lock(chk_lock)
);

// File: tb/sim_spi_cmd_seq.sv
`timescale 1ns/1ps
module sim_spi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spi_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: captures bytes, answers 0xA0 + byte position in frame
    logic [7:0] cap [0:127];
    int ncap = 0, nframe = 0, bitc = 0, bytec = 0;
    logic [7:0] shreg = '0;
    logic [7:0] resp;
    assign resp     = 8'(8'hA0 + bytec);
    assign spi_miso = spi_cs_n ? 1'b0 : resp[3'(7 - bitc)];

    always @(negedge spi_cs_n) begin
        nframe = nframe + 1; bitc = 0; bytec = 0;
    end
    always @(posedge spi_sck) begin
        shreg = {shreg[6:0], spi_mosi};
        bitc  = bitc + 1;
        if (bitc == 8) begin
            if (ncap < 128) cap[ncap] = shreg;
            ncap = ncap + 1; bitc = 0; bytec = bytec + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = 16'(v);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 7'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic clr_cap();
        ncap = 0; nframe = 0;
    endtask

    task automatic wait_idle();
        int s;
        for (int i = 0; i < 20000; i++) begin
            rd(1, s);
            if ((s & 1) == 0) break;
        end
    endtask

    task automatic t_reset();
        int v;
        rd(1, v); chk("R1 status", v, 0);
        rd(0, v); chk("R1 control", v, 0);
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 sck", int'(spi_sck), 0);
    endtask

    task automatic t_program();
        int v;
        wr(8, 8'h03); wr(9, 8'h02); wr(10, 8'h9F); wr(11, 8'h06);
        wr(12, 8'h00); wr(13, 8'h05); wr(14, 8'h00); wr(15, 8'h00);
        wr(5, 16'h004E);
        wr(4, 16'h5006);
        rd(10, v); chk("R2 menu entry 2", v, 8'h9F);
        rd(5, v);  chk("R2 type word", v, 16'h004E);
        rd(4, v);  chk("R2 prefix word", v, 16'h5006);
    endtask

    task automatic t_read_addr();
        int v;
        clr_cap();
        wr(2, 16'h3456); wr(3, 16'h0012);
        wr(0, 16'h0303);
        wait_idle();
        rd(0, v); chk("R2 control readback", v, 16'h0302);
        chk("R3 frames", nframe, 1);
        chk("R3 byte count", ncap, 8);
        chk("R3 opcode", int'(cap[0]), 8'h03);
        chk("R3 addr hi", int'(cap[1]), 8'h12);
        chk("R3 addr mid", int'(cap[2]), 8'h34);
        chk("R3 addr lo", int'(cap[3]), 8'h56);
        chk("R4 read fill mosi", int'(cap[4]), 8'hFF);
        for (int i = 0; i < 4; i++) begin
            rd(64 + i, v); chk("R4 read buffer", v, 8'hA4 + i);
        end
        rd(1, v); chk("R9 done set", v, 16'h0002);
        chk("R12 cs_n after", int'(spi_cs_n), 1);
        chk("R12 sck after", int'(spi_sck), 0);
    endtask

    task automatic t_w1c();
        int v;
        wr(1, 16'h0006);
        rd(1, v); chk("R9 w1c", v, 0);
    endtask

    task automatic t_write_noaddr();
        clr_cap();
        wr(64, 8'hC1); wr(65, 8'hC2);
        wr(0, 16'h0133);
        wait_idle();
        chk("R4 write count", ncap, 3);
        chk("R4 write op", int'(cap[0]), 8'h06);
        chk("R4 write byte0", int'(cap[1]), 8'hC1);
        chk("R4 write byte1", int'(cap[2]), 8'hC2);
        wr(1, 16'h0006);
    endtask

    task automatic t_atomic();
        clr_cap();
        wr(2, 16'h0100); wr(3, 16'h0000);
        wr(0, 16'h001D);
        wait_idle();
        chk("R5 two frames", nframe, 2);
        chk("R5 byte count", ncap, 5);
        chk("R5 prefix 1 chosen", int'(cap[0]), 8'h50);
        chk("R5 main opcode", int'(cap[1]), 8'h02);
        chk("R5 addr lo", int'(cap[4]), 8'h00);
        chk("R5 addr mid", int'(cap[3]), 8'h01);
        wr(1, 16'h0006);
    endtask

    task automatic t_nodata();
        clr_cap();
        wr(0, 16'h0721);
        wait_idle();
        chk("R6 opcode only", ncap, 1);
        chk("R6 opcode", int'(cap[0]), 8'h9F);
        wr(1, 16'h0006);
    endtask

    task automatic t_zero_op();
        int v;
        clr_cap();
        wr(0, 16'h0041);
        repeat (40) @(negedge clk);
        rd(1, v); chk("R7 blocked only", v, 16'h0004);
        chk("R7 no frame", nframe, 0);
        wr(1, 16'h0004);
    endtask

    task automatic t_length();
        int v;
        clr_cap();
        wr(0, 16'h0903);
        repeat (40) @(negedge clk);
        rd(1, v); chk("R8 len 10 blocked", v, 16'h0004);
        chk("R8 len 10 no frame", nframe, 0);
        wr(1, 16'h0004);
        wr(0, 16'h0F53);
        wait_idle();
        chk("R8 len 16 bytes", ncap, 17);
        rd(64 + 15, v); chk("R8 len 16 last byte", v, 8'hB0);
        rd(1, v); chk("R8 len 16 done", v, 16'h0002);
        wr(1, 16'h0006);
    endtask

    task automatic t_busy_go();
        int v;
        clr_cap();
        wr(2, 16'h0000); wr(3, 16'h0000);
        wr(0, 16'h0703);
        repeat (20) @(negedge clk);
        wr(0, 16'h0021);
        wait_idle();
        chk("R10 byte count", ncap, 12);
        chk("R10 opcode kept", int'(cap[0]), 8'h03);
        chk("R10 single frame", nframe, 1);
        rd(0, v); chk("R10 control kept", v, 16'h0702);
        wr(1, 16'h0006);
    endtask

    task automatic t_lock();
        int v;
        wr(1, 16'h0008);
        wr(10, 8'h77); wr(5, 16'h0000); wr(4, 16'h0000);
        rd(10, v); chk("R11 menu frozen", v, 8'h9F);
        rd(5, v);  chk("R11 type frozen", v, 16'h004E);
        rd(4, v);  chk("R11 prefix frozen", v, 16'h5006);
        wr(1, 16'h0000);
        rd(1, v);  chk("R11 lock sticky", v, 16'h0008);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_read_addr();
        t_w1c();
        t_write_noaddr();
        t_atomic();
        t_nodata();
        t_zero_op();
        t_length();
        t_busy_go();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule